// File: doc/BRIEF.md
# Supply Control and Fault Status Register Block

This block is the register file between a serial host port and three on-chip supply generators. Each supply has a level code and an on/off bit that the host writes. The analog side reports undervoltage, current-limit and thermal flags. The block brings these flags into the clock domain through a synchronizer and shows them two ways: as a live copy, and as a sticky copy that the host clears bit by bit. Any sticky bit the host has unmasked pulls an active-low interrupt line.

Two safety functions sit in the same block. After reset, a start-up window keeps the supplies off and the clocking outputs in high impedance, and it ignores host writes until the internal logic has settled. A live thermal-shutdown flag forces every supply off and the outputs to high impedance at once. It also clears the stored enable bits, so each supply comes back only when the host writes it again after the flag has gone away.

Top module: `supply_fault_regs`

## Requirements
- R1: After reset, every level code, enable bit, sticky bit and mask bit is 0, `irq_n` is 1 and `ready` is 0.
- R2: For INIT_CYCLES clock cycles after reset, `ready` is 0, `out_hiz` is 1, `supply_en` is 0 and host writes are ignored. After that window, `ready` is 1.
- R3: Addresses 0, 1 and 2 hold the control word of supply 0, 1 and 2. Bits [3:0] are the level code and bit 4 is the enable; bits [7:5] read as 0. Supply k drives `supply_level[4k+3:4k]` and `supply_en[k]`.
- R4: Address 3 reads the live flags, which are `fault_raw` seen through two flops. Bit 2k is undervoltage of supply k, bit 2k+1 is current limit of supply k, bit 6 is thermal warning and bit 7 is thermal shutdown.
- R5: Address 4 holds the sticky flags, in the same bit layout. A sticky bit is set one cycle after its live bit rises, and it stays set after the raw flag drops.
- R6: Writing 1 to a bit at address 4 clears that sticky bit, and writing 0 leaves it unchanged. A clear has no effect while the live bit is still 1.
- R7: Address 5 is the interrupt mask, in the same bit layout, where 1 means the bit may interrupt. `irq_n` is 0 exactly when some sticky bit and its mask bit are both 1.
- R8: While the live thermal-shutdown bit is 1, `supply_en` is 0 and `out_hiz` is 1. The stored enable bits are cleared, and writes in this state store the level code but not the enable. After the flag clears, a supply comes back on only through a new write.
- R9: Thermal warning only sets its status bits. It does not change `supply_en` or `out_hiz`.
- R10: Addresses 6 to 15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| fault_raw | input | 8 | Asynchronous flags from the analog blocks |
| supply_en | output | 3 | Per-supply on command |
| supply_level | output | 12 | Per-supply level codes, 4 bits each |
| out_hiz | output | 1 | Request for high impedance on the clocking outputs |
| ready | output | 1 | Start-up window finished |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The flag path is driven with single-bit and multi-bit raw patterns. Each pattern is paired with a mask that either covers the flag or misses it, so a wrong bit position, a missing mask gate or a sticky bit that never sets shows up as a wrong interrupt level. Every pattern is removed before it is cleared, which separates the live copy from the sticky copy. A clear is also tried while the raw flag is still held, which tells a true clear from one that ignores the live level. The thermal patterns are kept apart: a warning alone must leave the supplies running, while a shutdown must drop them and keep them off until the host writes them again.

// File: rtl/supply_fault_pkg.sv
package supply_fault_pkg;
  localparam int NUM_SUP   = 3;
  localparam int LVL_W     = 4;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 4;
  localparam int FLAG_W    = 2 * NUM_SUP + 2;
  localparam int BIT_TWARN = 2 * NUM_SUP;
  localparam int BIT_TSHUT = 2 * NUM_SUP + 1;

  localparam logic [ADDR_W-1:0] A_LIVE   = ADDR_W'(NUM_SUP);
  localparam logic [ADDR_W-1:0] A_STICKY = ADDR_W'(NUM_SUP + 1);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(NUM_SUP + 2);

  // Next sticky value: a rise sets, a clear only acts where the live flag is low.
  function automatic logic [FLAG_W-1:0] sticky_next(
    input logic [FLAG_W-1:0] cur,
    input logic [FLAG_W-1:0] live,
    input logic [FLAG_W-1:0] rise,
    input logic [FLAG_W-1:0] clr);
    return (cur & ~(clr & ~live)) | rise;
  endfunction

  function automatic logic irq_level(input logic [FLAG_W-1:0] sticky,
                                     input logic [FLAG_W-1:0] mask);
    return ~|(sticky & mask);
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_word(input logic [LVL_W-1:0] lvl,
                                                  input logic en);
    logic [DATA_W-1:0] w;
    w = '0;
    w[LVL_W-1:0] = lvl;
    w[LVL_W] = en;
    return w;
  endfunction
endpackage

// File: rtl/sf_flag_sync.sv
module sf_flag_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] live,
  output logic [W-1:0] rise
);
  logic [W-1:0] meta_q, live_q, prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        live_q[i] <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= raw[i];
        live_q[i] <= meta_q[i];
        prev_q[i] <= live_q[i];
      end
    end
  end

  assign live = live_q;
  assign rise = live_q & ~prev_q;
endmodule

// File: rtl/sf_fault_bank.sv
module sf_fault_bank
  import supply_fault_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sticky,
  input  logic              wr_mask,
  input  logic [DATA_W-1:0] wdata,
  input  logic [FLAG_W-1:0] live,
  input  logic [FLAG_W-1:0] rise,
  output logic [FLAG_W-1:0] sticky,
  output logic [FLAG_W-1:0] mask,
  output logic              irq_n
);
  logic [FLAG_W-1:0] clr;

  assign clr = wr_sticky ? wdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= '0;
      mask   <= '0;
    end else begin
      sticky <= sticky_next(sticky, live, rise, clr);
      if (wr_mask) mask <= wdata[FLAG_W-1:0];
    end
  end

  assign irq_n = irq_level(sticky, mask);
endmodule

// File: rtl/sf_supply_regs.sv
module sf_supply_regs
  import supply_fault_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_ok,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     shutdown,
  output logic [NUM_SUP*LVL_W-1:0] levels,
  output logic [NUM_SUP-1:0]       en_store
);
  for (genvar k = 0; k < NUM_SUP; k++) begin : g_sup
    logic hit;
    assign hit = wr_ok && (addr == ADDR_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        levels[k*LVL_W +: LVL_W] <= '0;
        en_store[k] <= 1'b0;
      end else if (hit) begin
        levels[k*LVL_W +: LVL_W] <= wdata[LVL_W-1:0];
        en_store[k] <= wdata[LVL_W] & ~shutdown;
      end else if (shutdown) begin
        en_store[k] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/supply_fault_regs.sv
module supply_fault_regs
  import supply_fault_pkg::*;
#(
  parameter int INIT_CYCLES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [FLAG_W-1:0]        fault_raw,
  output logic [NUM_SUP-1:0]       supply_en,
  output logic [NUM_SUP*LVL_W-1:0] supply_level,
  output logic                     out_hiz,
  output logic                     ready,
  output logic                     irq_n
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  logic [CNT_W-1:0]   init_cnt;
  logic               init_busy;
  logic               wr_ok;
  logic [FLAG_W-1:0]  fault_live, fault_rise, sticky, mask;
  logic [NUM_SUP-1:0] en_store;
  logic               shutdown;

  // Start-up window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_cnt <= '0;
    else if (init_busy) init_cnt <= init_cnt + 1'b1;
  end
  assign init_busy = (init_cnt != CNT_W'(INIT_CYCLES));
  assign ready     = ~init_busy;
  assign wr_ok     = bus_we & ready;

  sf_flag_sync #(.W(FLAG_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(fault_raw),
    .live(fault_live), .rise(fault_rise)
  );

  assign shutdown = fault_live[BIT_TSHUT];

  sf_fault_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_sticky(wr_ok && bus_addr == A_STICKY),
    .wr_mask(wr_ok && bus_addr == A_MASK),
    .wdata(bus_wdata), .live(fault_live), .rise(fault_rise),
    .sticky(sticky), .mask(mask), .irq_n(irq_n)
  );

  sf_supply_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .addr(bus_addr),
    .wdata(bus_wdata), .shutdown(shutdown),
    .levels(supply_level), .en_store(en_store)
  );

  assign supply_en = en_store & ~{NUM_SUP{shutdown | init_busy}};
  assign out_hiz   = shutdown | init_busy;

  // Read mux
  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_SUP; k++)
      if (bus_addr == ADDR_W'(k))
        bus_rdata = ctrl_word(supply_level[k*LVL_W +: LVL_W], en_store[k]);
    if (bus_addr == A_LIVE)   bus_rdata[FLAG_W-1:0] = fault_live;
    if (bus_addr == A_STICKY) bus_rdata[FLAG_W-1:0] = sticky;
    if (bus_addr == A_MASK)   bus_rdata[FLAG_W-1:0] = mask;
  end
endmodule

// File: rtl/supply_fault_regs_checker.sv
module supply_fault_regs_checker
  import supply_fault_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_we,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [FLAG_W-1:0]        fault_live,
  input logic [FLAG_W-1:0]        fault_rise,
  input logic [FLAG_W-1:0]        sticky,
  input logic [FLAG_W-1:0]        mask,
  input logic [NUM_SUP-1:0]       supply_en,
  input logic                     out_hiz,
  input logic                     ready,
  input logic                     irq_n
);
  a_r8_shutdown_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault_live[BIT_TSHUT] |-> (supply_en == '0 && out_hiz));

  a_r2_off_during_init: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (supply_en == '0 && out_hiz));

  a_r7_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> irq_n);

  a_r5_rise_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_rise != '0) |=> (($past(fault_rise) & ~sticky) == '0));

  a_r6_sticky_holds_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_STICKY) |=> (($past(sticky) & ~sticky) == '0));
endmodule

bind supply_fault_regs supply_fault_regs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .fault_live(fault_live), .fault_rise(fault_rise), .sticky(sticky),
  .mask(mask), .supply_en(supply_en), .out_hiz(out_hiz),
  .ready(ready), .irq_n(irq_n)
);

// File: tb/supply_fault_regs_bench.sv
module supply_fault_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  fault_raw = '0;
  logic [2:0]  supply_en;
  logic [11:0] supply_level;
  logic        out_hiz, ready, irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  supply_fault_regs u_supply_fault_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault_raw(fault_raw),
    .supply_en(supply_en), .supply_level(supply_level), .out_hiz(out_hiz),
    .ready(ready), .irq_n(irq_n)
  );

  // {raw pattern, mask}
  localparam logic [15:0] VEC [6] = '{
    16'h01_01, 16'h02_01, 16'h0C_FF, 16'h30_0F, 16'h40_40, 16'h21_20
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 ready", ready, 0);
    check("R1 irq_n", irq_n, 1);
    for (int a = 0; a < 6; a++) begin
      rd(4'(a), d);
      check("R1 reg", d, 0);
    end
    // R2 write during init ignored
    check("R2 hiz in init", out_hiz, 1);
    wr(4'd0, 8'h1F);
    rd(4'd0, d);
    check("R2 init write ignored", d, 0);
    check("R2 en off in init", supply_en, 0);
    repeat (12) @(negedge clk);
    check("R2 ready", ready, 1);
    check("R2 hiz released", out_hiz, 0);

    // R3 control fields
    wr(4'd1, 8'h1A);
    rd(4'd1, d);
    check("R3 readback", d, 8'h1A);
    check("R3 level out", supply_level, 12'h0A0);
    check("R3 enable out", supply_en, 3'b010);
    wr(4'd2, 8'hE3);
    rd(4'd2, d);
    check("R3 upper bits zero", d, 8'h03);
    check("R3 level2", supply_level, 12'h3A0);

    // R10 unmapped
    wr(4'd9, 8'hFF);
    rd(4'd9, d);
    check("R10 unmapped read", d, 0);
    rd(4'd1, d);
    check("R10 no side effect", d, 8'h1A);

    // R4 R5 R6 R7 table walk
    foreach (VEC[i]) begin
      logic [7:0] raw, msk;
      raw = VEC[i][15:8]; msk = VEC[i][7:0];
      wr(4'd5, msk);
      fault_raw = raw;
      settle();
      rd(4'd3, d);
      check("R4 live", d, raw);
      check("R7 irq", irq_n, ((raw & msk) == 0));
      fault_raw = '0;
      settle();
      rd(4'd4, d);
      check("R5 sticky held", d, raw);
      wr(4'd4, 8'hFF);
      rd(4'd4, d);
      check("R6 cleared", d, 0);
      check("R7 irq released", irq_n, 1);
    end

    // R6 clear while raw active, zero write
    fault_raw = 8'h01;
    settle();
    wr(4'd4, 8'h00);
    rd(4'd4, d);
    check("R6 zero write no effect", d, 8'h01);
    wr(4'd4, 8'h01);
    rd(4'd4, d);
    check("R6 clear blocked while live", d, 8'h01);
    fault_raw = '0;
    settle();
    wr(4'd4, 8'hFF);

    // R9 warning leaves supplies on
    wr(4'd0, 8'h15); wr(4'd1, 8'h15); wr(4'd2, 8'h15);
    check("R9 baseline en", supply_en, 3'b111);
    fault_raw = 8'h40;
    settle();
    check("R9 en unchanged", supply_en, 3'b111);
    check("R9 hiz unchanged", out_hiz, 0);
    fault_raw = '0;
    settle();

    // R8 shutdown
    fault_raw = 8'h80;
    settle();
    check("R8 en forced off", supply_en, 0);
    check("R8 hiz", out_hiz, 1);
    rd(4'd1, d);
    check("R8 stored en cleared", d, 8'h05);
    wr(4'd0, 8'h17);
    rd(4'd0, d);
    check("R8 write in shutdown", d, 8'h07);
    fault_raw = '0;
    settle();
    check("R8 stays off after clear", supply_en, 0);
    check("R8 hiz released", out_hiz, 0);
    wr(4'd0, 8'h15);
    check("R8 rewrite restores", supply_en, 3'b001);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule